// File: doc/BRIEF.md
# Latched Serial-to-Parallel LED Driver Register

This block takes a serial bit stream and presents it on a wide set of open-drain style LED outputs. A shift strobe moves the serial bit, inverted, into the first stage and advances every other stage by one place. A separate latch strobe copies the whole shift chain into an output latch, which drives the pins. The last shift stage is also brought out on a cascade pin, so several blocks can be chained into a longer register.

Both strobes and the serial data come from a slower external interface. They pass through a synchronizer in the system clock domain, and only their rising edges act. Each open-drain pin is modelled as two signals: a pull-low request and a drive enable. A latched 0 lights its LED. A latched 1 leaves the pin floating.

The active-low reset is asynchronous. It presets both registers to all ones, which means all LEDs are off. An output-disable input floats every parallel pin but does not stop the register activity behind them.

Top module: `led_sipo_latch`

## Requirements
- R1: While `rst_n` is low, every bit of `drive_en` is 0 and `cascade_out` is 0. Reset presets every shift stage and every latch stage to 1, so right after release `pull_low` is all 0 and `cascade_out` is 1.
- R2: A strobe acts only on a rising edge seen after synchronization. A strobe that stays high, or that falls, changes nothing. A strobe held high through the release of reset does not count as an edge.
- R3: Each shift edge loads the inverse of `ser_in` into stage 0 and moves stage i into stage i+1. `ser_in` is sampled along with the strobe, so it must be held stable around the rising edge.
- R4: `cascade_out` equals the last shift stage (index WIDTH-1) whenever reset is inactive.
- R5: Each latch edge copies all WIDTH shift stages into the latch, with stage i going to latch bit i.
- R6: When shift and latch edges are detected in the same cycle, the latch captures the contents from before that shift.
- R7: While `out_dis` is 1, `drive_en` is all 0 and `cascade_out` keeps its normal value.
- R8: `out_dis` has no effect on shifting or latching. Edges seen while it is high still update both registers.
- R9: Output encoding:
  - `pull_low[i]` is the inverse of latch bit i.
  - `drive_en[i]` is `pull_low[i]` gated by `out_dis` low and reset inactive.
- R10: Latency: if a strobe rises before clock edge k, its effect first appears at the outputs after edge k+2, and not after edges k or k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, presets both registers |
| ser_in | input | 1 | Serial data, stored inverted |
| shift_strobe | input | 1 | Shift strobe, acts on its rising edge |
| latch_strobe | input | 1 | Latch strobe, acts on its rising edge |
| out_dis | input | 1 | High floats all parallel outputs |
| pull_low | output | WIDTH | Per-pin request to pull low (inverse of latch bit) |
| drive_en | output | WIDTH | Per-pin driver enable; a pin is driven only when this is 1 |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The assertions assume that every strobe pulse, high and low, lasts at least SYNC_STAGES+1 clock cycles. This lets each rising edge be seen exactly once. They also assume that `ser_in` is stable while the strobe passes through the synchronizer. The stimulus raises a strobe at a falling clock edge and holds it for four cycles. It then holds the strobe low for at least three cycles. `ser_in` is set together with the strobe and held until the strobe falls. Random mixes of shift, latch, combined strobes and output-disable settings are checked against a model kept in the bench. Directed cases cover the reset state, latency, and reset release with a strobe held high.

// File: rtl/led_sipo_latch.sv
module led_sipo_latch #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_strobe,
  input  logic             latch_strobe,
  input  logic             out_dis,
  output logic [WIDTH-1:0] pull_low,
  output logic [WIDTH-1:0] drive_en,
  output logic             cascade_out
);
  localparam int HIST = SYNC_STAGES + 1;

  logic [HIST-1:0]        shf_pipe, lat_pipe;
  logic [SYNC_STAGES-1:0] din_pipe;
  logic [WIDTH-1:0]       chain_q, hold_q;
  logic                   shift_evt, latch_evt, din_s;

  // sync history presets high so a strobe held through reset is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_pipe <= '1;
      lat_pipe <= '1;
      din_pipe <= '0;
    end else begin
      shf_pipe <= {shf_pipe[HIST-2:0], shift_strobe};
      lat_pipe <= {lat_pipe[HIST-2:0], latch_strobe};
      din_pipe <= {din_pipe[SYNC_STAGES-2:0], ser_in};
    end
  end

  assign shift_evt = shf_pipe[HIST-2] & ~shf_pipe[HIST-1];
  assign latch_evt = lat_pipe[HIST-2] & ~lat_pipe[HIST-1];
  assign din_s     = din_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      hold_q  <= '1;
    end else begin
      if (shift_evt) chain_q <= {chain_q[WIDTH-2:0], ~din_s};
      if (latch_evt) hold_q  <= chain_q;
    end
  end

  assign pull_low    = ~hold_q;
  assign drive_en    = pull_low & {WIDTH{~out_dis & rst_n}};
  assign cascade_out = chain_q[WIDTH-1] & rst_n;

  always_comb begin
    if (rst_n === 1'b0) begin
      AST_DARK_IN_RESET: assert (drive_en == '0 && cascade_out == 1'b0); // R1
    end
  end

  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0])); // R3

  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(chain_q)); // R2

  AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> hold_q == $past(chain_q)); // R5

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(pull_low)); // R2

  AST_DISABLE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |-> drive_en == '0); // R7

  AST_CASCADE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> cascade_out == $past(chain_q[WIDTH-2])); // R4
endmodule

// File: tb/led_sipo_latch_tb.sv
module led_sipo_latch_tb;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0;
  logic shift_strobe = 1'b0, latch_strobe = 1'b0, out_dis = 1'b0;
  logic [W-1:0] pull_low, drive_en;
  logic cascade_out;

  int checks = 0, failures = 0;
  logic [W-1:0] m_sh, m_lat;

  always #2 clk = ~clk;

  led_sipo_latch #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_strobe(shift_strobe),
    .latch_strobe(latch_strobe), .out_dis(out_dis), .pull_low(pull_low),
    .drive_en(drive_en), .cascade_out(cascade_out));

  function automatic logic [W-1:0] exp_pull(input logic [W-1:0] lat);
    return ~lat;
  endfunction

  function automatic logic [W-1:0] exp_en(input logic [W-1:0] lat, input logic dis);
    return dis ? '0 : ~lat;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] pl, input logic [W-1:0] en, input logic cas);
    checks++;
    if (pull_low !== pl || drive_en !== en || cascade_out !== cas) begin
      failures++;
      $display("FAIL %s: pull_low=%h drive_en=%h cascade=%b expected %h %h %b",
               req, pull_low, drive_en, cascade_out, pl, en, cas);
    end
  endtask

  task automatic chk_model(input string req);
    chk(req, exp_pull(m_lat), exp_en(m_lat, out_dis), m_sh[W-1]);
  endtask

  task automatic strobe(input logic do_sh, input logic do_la, input logic d);
    @(negedge clk);
    ser_in = d;
    shift_strobe = do_sh;
    latch_strobe = do_la;
    repeat (4) @(negedge clk);
    shift_strobe = 1'b0;
    latch_strobe = 1'b0;
    repeat (3) @(negedge clk);
    if (do_la) m_lat = m_sh;
    if (do_sh) m_sh = {m_sh[W-2:0], ~d};
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    m_sh = '1;
    m_lat = '1;
    @(negedge clk);
    chk("R1 after release", '0, '0, 1'b1);

    // R3 directed: a high input is stored as 0
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R3 inverted store", 16'h0001, 16'h0001, 1'b1);

    // R10 latency on a latch
    strobe(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    latch_strobe = 1'b1;
    @(negedge clk);
    chk("R10 after edge k", 16'h0001, 16'h0001, 1'b1);
    @(negedge clk);
    chk("R10 after edge k+1", 16'h0001, 16'h0001, 1'b1);
    @(negedge clk);
    chk("R10 after edge k+2", 16'h0002, 16'h0002, 1'b1);
    // R2: held strobe does nothing more
    repeat (3) @(negedge clk);
    latch_strobe = 1'b0;
    m_lat = m_sh;
    repeat (3) @(negedge clk);
    chk_model("R2 held strobe");

    // R6 simultaneous shift and latch
    strobe(1'b1, 1'b1, 1'b1);
    chk_model("R6 pre-shift capture");
    strobe(1'b0, 1'b1, 1'b0);
    chk_model("R5 post-shift capture");

    // R4 cascade: push 16 bits, cascade follows the last stage
    for (int i = 0; i < W; i++) begin
      strobe(1'b1, 1'b0, i[0]);
      chk_model("R4 cascade");
    end

    // R7 / R8 directed
    @(negedge clk);
    out_dis = 1'b1;
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    chk_model("R7 disabled floats");
    out_dis = 1'b0;
    #1;
    chk_model("R8 updates while disabled");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      out_dis = 1'($urandom_range(0, 3) == 0);
      case (op)
        3'd0, 3'd1, 3'd2: strobe(1'b1, 1'b0, 1'($urandom));
        3'd3:             strobe(1'b0, 1'b1, 1'($urandom));
        default:          strobe(1'b1, 1'b1, 1'($urandom));
      endcase
      chk_model(out_dis ? "R7 random" : "R9 random");
    end
    out_dis = 1'b0;

    // R1 asynchronous reset mid-run, with a shift strobe held through release (R2)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", '0, '0, 1'b0);
    shift_strobe = 1'b1;
    ser_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    m_sh = '1;
    m_lat = '1;
    repeat (6) @(negedge clk);
    shift_strobe = 1'b0;
    repeat (3) @(negedge clk);
    strobe(1'b0, 1'b1, 1'b0);
    chk_model("R2 no edge on release");

    finish_run();
  end
endmodule